// File: doc/BRIEF.md
# Electrically Erasable EPROM Cycle Model

A synthesizable, clock-synchronous model of a byte-wide EPROM with electrical chip erase. It stands in for the real part when a programmer controller is being verified. The two high-voltage pins are reduced to digital flags: a two-bit supply-level code and a single flag for the high-voltage condition on address bit 9. The model works out the operating mode from these flags and the three active-low strobes, chip enable, output enable and program. It drives the addressed byte or disables its outputs, and it applies program and erase pulses to the storage array.

The full part holds 131072 bytes, which needs 17 address bits. The default depth is smaller so that simulation stays light, and `ADDR_W` restores the full size. Every input is sampled on the rising clock edge. Read data and the output enable are registered, so they appear one clock after the inputs that select them.

Top module: `eeprom_cycle_model`

## Requirements
- R1: After reset every byte of the array reads FF hex, `dout_oe` is 0 and `dout` is 00 hex.
- R2: When `ce_n` is 1, `dout_oe` is 0 one clock later, whatever `oe_n` and `pgm_n` are. A program pulse given while `ce_n` is 1 leaves the array unchanged.
- R3: When `ce_n` is 0 and `oe_n` is 1, `dout_oe` is 0 one clock later. When `ce_n` is 0, `oe_n` is 0 and `vpp_lvl` is 00 (normal) or 11 (also treated as normal), `dout_oe` is 1 one clock later and `dout` holds the byte at `addr`. Whenever `dout_oe` is 0, `dout` is 00.
- R4: A program pulse writes the addressed byte. The pulse is `pgm_n` held at 0 for one or more clocks while `vpp_lvl` is 01, `ce_n` is 0 and `oe_n` is 1. The write uses the `addr` and `din` sampled in the first low clock and takes effect on the clock where `pgm_n` is first sampled 1 again.
- R5: Programming only clears bits: the byte becomes its old value AND `din`. Programming FF hex over a byte leaves it unchanged.
- R6: An erase pulse sets every byte to FF hex. It is a low pulse on `pgm_n` while `vpp_lvl` is 10, `a9_hv` is 1, `addr[0]` is 0, `ce_n` is 0 and `oe_n` is 1.
- R7: With `vpp_lvl` at 01 or 10 (verify), `ce_n` 0, `oe_n` 0 and `pgm_n` 1, the addressed byte is driven one clock later. With the supply raised and `pgm_n` 0, `dout_oe` is 0.
- R8: If the mode conditions fail in any clock of the low period, the pulse is cancelled and the array is unchanged.
- R9: A pulse whose mode conditions are not met has no effect on the array. Examples are a supply code of 00 or 11, or erase attempted with `addr[0]` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Active-low reset; fills the array with ones |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data to be programmed |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| pgm_n | input | 1 | Active-low program/erase strobe |
| vpp_lvl | input | 2 | Supply level: 00 normal, 01 program, 10 erase, 11 normal |
| a9_hv | input | 1 | High voltage present on address bit 9 |
| dout | output | 8 | Registered read data, 00 when disabled |
| dout_oe | output | 1 | Registered output-drive enable |

## Verification
The assertions assume that every input is stable around the rising clock edge and that reset is applied from time zero. The array properties also assume that `pgm_n` is low for at least one sampled clock before it rises again. The bench changes every input only on falling clock edges. Each pulse holds the strobe low for three sampled clocks, and the bench returns to an idle state between scenarios. In that state `ce_n` is high and the supply code is normal, so one scenario's leftover mode cannot arm the next pulse.

// File: rtl/eeprom_cycle_model.sv
module eeprom_cycle_model #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic [1:0]        vpp_lvl,
  input  logic              a9_hv,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [1:0] LVL_NORM  = 2'd0;
  localparam logic [1:0] LVL_PROG  = 2'd1;
  localparam logic [1:0] LVL_ERASE = 2'd2;
  localparam logic [1:0] LVL_ALT   = 2'd3;

  typedef enum logic [1:0] {PEND_NONE, PEND_PROG, PEND_ERASE} pend_t;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              pgm_q;
  pend_t             pend;
  logic [ADDR_W-1:0] wa_q;
  logic [DATA_W-1:0] wd_q;

  wire lvl_normal = (vpp_lvl == LVL_NORM) || (vpp_lvl == LVL_ALT);
  wire prog_ok    = (vpp_lvl == LVL_PROG) && !ce_n && oe_n;
  wire erase_ok   = (vpp_lvl == LVL_ERASE) && a9_hv && !addr[0] && !ce_n && oe_n;
  wire rd_ok      = !ce_n && !oe_n && (lvl_normal || pgm_n);

  wire pulse_start  = !pgm_n && pgm_q;
  wire pulse_end    = pgm_n && !pgm_q;
  wire commit_prog  = pulse_end && (pend == PEND_PROG);
  wire commit_erase = pulse_end && (pend == PEND_ERASE);
  wire cond_lost    = ((pend == PEND_PROG) && !prog_ok) ||
                      ((pend == PEND_ERASE) && !erase_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgm_q   <= 1'b1;
      pend    <= PEND_NONE;
      wa_q    <= '0;
      wd_q    <= '0;
      dout    <= '0;
      dout_oe <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      pgm_q   <= pgm_n;
      dout_oe <= rd_ok;
      dout    <= rd_ok ? mem[addr] : '0;
      if (pulse_start) begin
        pend <= prog_ok ? PEND_PROG : (erase_ok ? PEND_ERASE : PEND_NONE);
        wa_q <= addr;
        wd_q <= din;
      end else if (!pgm_n && cond_lost) begin
        pend <= PEND_NONE;
      end else if (pulse_end) begin
        pend <= PEND_NONE;
        if (commit_prog) mem[wa_q] <= mem[wa_q] & wd_q;
        if (commit_erase)
          for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end
    end
  end

  p_standby_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !dout_oe);

  p_oe_high_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && !ce_n) |=> !dout_oe);

  p_read_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && vpp_lvl == LVL_NORM) |=> dout_oe);

  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> dout == '0);

  p_and_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_prog |=> mem[$past(wa_q)] == ($past(mem[wa_q]) & $past(wd_q)));

  p_erase_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_erase |=> (mem[0] == '1) && (mem[DEPTH-1] == '1));

  p_no_pend_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_n && pgm_q) |-> pend == PEND_NONE);

endmodule

// File: tb/eeprom_cycle_model_tb.sv
module eeprom_cycle_model_tb_top;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, a9_hv = 1'b0;
  logic [1:0]    vpp_lvl = 2'd0;
  logic [7:0]    dout;
  logic          dout_oe;

  logic [7:0] expm [DEPTH];
  int runs = 0, fails = 0;

  always #10 clk = ~clk;

  eeprom_cycle_model #(.ADDR_W(AW), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n),
    .oe_n(oe_n), .pgm_n(pgm_n), .vpp_lvl(vpp_lvl), .a9_hv(a9_hv),
    .dout(dout), .dout_oe(dout_oe));

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ce_n = 1; oe_n = 1; pgm_n = 1; vpp_lvl = 2'd0; a9_hv = 0;
  endtask

  task automatic read_chk(input string req, input logic [1:0] v, input logic [AW-1:0] a);
    @(negedge clk);
    ce_n = 0; oe_n = 0; pgm_n = 1; vpp_lvl = v; addr = a;
    @(negedge clk);
    check(req, {dout_oe, dout}, {1'b1, expm[a]});
  endtask

  task automatic pulse(input logic [1:0] v, input logic a9, input logic ce,
                       input logic [AW-1:0] a, input logic [7:0] d, input logic drop);
    @(negedge clk);
    vpp_lvl = v; a9_hv = a9; ce_n = ce; oe_n = 1; addr = a; din = d; pgm_n = 1;
    @(negedge clk); pgm_n = 0;
    @(negedge clk); if (drop) vpp_lvl = 2'd0;
    @(negedge clk); vpp_lvl = v;
    @(negedge clk); pgm_n = 1;
    idle();
  endtask

  task automatic t_reset();
    check("R1 outputs off", {dout_oe, dout}, 9'h000);
    read_chk("R1 array ones", 2'd0, 8'd5);
    read_chk("R1 array ones top", 2'd0, 8'(DEPTH-1));
    idle();
  endtask

  task automatic t_output_ctrl();
    @(negedge clk); ce_n = 1; oe_n = 0; pgm_n = 0; addr = 8'd2;
    @(negedge clk); check("R2 standby hiz", {dout_oe, dout}, 9'h000);
    ce_n = 0; oe_n = 1; pgm_n = 1;
    @(negedge clk); check("R3 oe high hiz", {dout_oe, dout}, 9'h000);
    read_chk("R3 read code 11", 2'd3, 8'd2);
    idle();
  endtask

  task automatic t_program();
    pulse(2'd1, 0, 0, 8'd3, 8'hA5, 0); expm[3] = 8'hA5;
    read_chk("R4 programmed byte", 2'd0, 8'd3);
    read_chk("R4 neighbour untouched", 2'd0, 8'd4);
    pulse(2'd1, 0, 0, 8'd3, 8'h0F, 0); expm[3] = 8'h05;
    read_chk("R5 and of old and new", 2'd0, 8'd3);
    pulse(2'd1, 0, 0, 8'd3, 8'hFF, 0);
    read_chk("R5 cannot set bits", 2'd0, 8'd3);
  endtask

  task automatic t_verify();
    read_chk("R7 program verify", 2'd1, 8'd3);
    @(negedge clk); pgm_n = 0;
    @(negedge clk); check("R7 raised supply pgm low hiz", {dout_oe, dout}, 9'h000);
    idle();
  endtask

  task automatic t_blocked();
    pulse(2'd1, 0, 1, 8'd7, 8'h00, 0);
    read_chk("R2 inhibit with ce high", 2'd0, 8'd7);
    pulse(2'd0, 0, 0, 8'd7, 8'h00, 0);
    read_chk("R9 normal supply no write", 2'd0, 8'd7);
    pulse(2'd3, 0, 0, 8'd7, 8'h00, 0);
    read_chk("R9 code 11 no write", 2'd0, 8'd7);
    pulse(2'd1, 0, 0, 8'd7, 8'h00, 1);
    read_chk("R8 dropped supply cancels", 2'd0, 8'd7);
  endtask

  task automatic t_erase();
    pulse(2'd1, 0, 0, 8'd9, 8'h3C, 0); expm[9] = 8'h3C;
    pulse(2'd2, 1, 0, 8'd1, 8'h00, 0);
    read_chk("R9 erase with a0 high", 2'd0, 8'd9);
    pulse(2'd2, 1, 0, 8'd0, 8'h00, 1);
    read_chk("R8 erase cancelled", 2'd0, 8'd3);
    pulse(2'd2, 1, 0, 8'd0, 8'h00, 0);
    for (int i = 0; i < DEPTH; i++) expm[i] = 8'hFF;
    read_chk("R7 erase verify", 2'd2, 8'd3);
    for (int i = 0; i < DEPTH; i++) read_chk("R6 all bytes ones", 2'd0, AW'(i));
    idle();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) expm[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_output_ctrl();
    t_program();
    t_verify();
    t_blocked();
    t_erase();
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #4000000;
    runs++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule